// File: doc/BRIEF.md
# Watchdog Timer with Built-in Tick Source

The block is a memory-mapped watchdog that owns its own periodic tick generator. The tick generator counts pulses of a fixed one-microsecond reference enable and emits a one-cycle tick after a programmable number of them, in either one-shot or repeating mode. The watchdog counts those ticks down from an 8-bit period, records every time the countdown runs out, and raises a sticky system reset request when it runs out for the fourth time in a row. Software keeps the system alive by issuing a start command, which reloads the countdown and clears the expiration history.

Stopping the watchdog is guarded: a stop command only takes effect if the write just before it on the command register was preceded by the key 0xC45A on the key register. A level interrupt can warn software at the first expiration, long before the reset request. The watchdog follows the tick generator only when its source-select field names that generator's ID.

A one-second timeout with the 1 MHz reference is obtained by a tick period of 250000 and a watchdog period equal to the timeout in seconds, since reset follows four expirations.

Top module: `wdog_tick`

## Requirements
- R1: The tick control register (offset 0x10) holds enable in bit 31, repeat mode in bit 30 and the tick period in reference pulses in bits [29:0]; with enable set and a nonzero period a tick occurs every period-th reference pulse after the write, a one-shot timer clears its enable after its first tick, and writing zero stops all ticks; the register reads back its fields.
- R2: The watchdog setup register (offset 0x0) holds the source ID in bits [2:0], the period in bits [11:4], interrupt enable in bit 12 and reset enable in bit 15, and reads back as written.
- R3: The status register (offset 0x4) reports running in bit 0, the current count in bits [11:4] and the expiration count in bits [13:12]; while running, each selected tick decrements the count, and a tick at count 1 reloads the period and increments the expiration count, which holds at 3.
- R4: Writing bit 0 of the command register (offset 0x8) starts or restarts the watchdog: count is reloaded from the period, expirations and the interrupt are cleared.
- R5: Writing bit 1 of the command register stops the watchdog only if the key 0xC45A was written to the key register (offset 0xC) since the last command write; otherwise it is ignored.
- R6: Any command-register write, including one with no bits set, consumes a pending key.
- R7: With interrupt enable set, irq rises at the first expiration and stays high until the next start command.
- R8: With reset enable set, rst_req rises at the fourth expiration and stays high until the block reset; with reset enable clear it never rises.
- R9: Ticks reach the watchdog only when the source ID field equals the generator's ID (5 by default); otherwise the count does not move.
- R10: After reset all registers read zero and irq and rst_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per reference microsecond |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench aims at the expiration boundary: a design that reloads at zero instead of at one, or wraps the expiration count, shows a status word one tick off or fires the reset early. It issues a stop without a key, a key followed by an empty command, and a stop landing in the same cycle as a tick; a design that accepts unkeyed stops, keeps a stale key, or lets the tick win would keep or lose the running bit wrongly. It also points the watchdog at a foreign ID, runs with reset enable cleared, and runs the generator one-shot and stopped, where a faulty design would keep counting or raise rst_req.

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int TID_W    = 3,
  parameter int TIMER_ID = 5,
  parameter int TPER_W   = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam logic [4:0]  A_CFG = 5'h00, A_STS = 5'h04, A_CMD = 5'h08,
                          A_KEY = 5'h0C, A_TMR = 5'h10;
  localparam logic [15:0] KEY   = 16'hC45A;
  localparam int          PW    = 8;

  logic              t_en, t_rep;
  logic [TPER_W-1:0] t_per, t_cnt;
  logic [TID_W-1:0]  sel;
  logic [PW-1:0]     per, cnt;
  logic              ie, re, run, unlk;
  logic [1:0]        exp_n;

  wire tmr_wr = bus_we && bus_addr == A_TMR;
  wire cfg_wr = bus_we && bus_addr == A_CFG;
  wire cmd_wr = bus_we && bus_addr == A_CMD;
  wire key_wr = bus_we && bus_addr == A_KEY;
  wire t_step = t_en && us_tick && t_per != '0;
  wire tick   = t_step && t_cnt == t_per - 1'b1;
  wire wd_tick = tick && sel == TID_W'(TIMER_ID);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t_en <= 1'b0; t_rep <= 1'b0; t_per <= '0; t_cnt <= '0;
    end else if (tmr_wr) begin
      t_en  <= bus_wdata[31];
      t_rep <= bus_wdata[30];
      t_per <= bus_wdata[TPER_W-1:0];
      t_cnt <= '0;
    end else if (t_step) begin
      if (tick) begin
        t_cnt <= '0;
        if (!t_rep) t_en <= 1'b0;
      end else t_cnt <= t_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel <= '0; per <= '0; ie <= 1'b0; re <= 1'b0;
    end else if (cfg_wr) begin
      sel <= bus_wdata[TID_W-1:0];
      per <= bus_wdata[11:4];
      ie  <= bus_wdata[12];
      re  <= bus_wdata[15];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; exp_n <= 2'd0; unlk <= 1'b0;
      irq <= 1'b0; rst_req <= 1'b0;
    end else if (cmd_wr) begin
      unlk <= 1'b0;
      if (bus_wdata[1] && unlk) run <= 1'b0;
      else if (bus_wdata[0]) begin
        run <= 1'b1; cnt <= per; exp_n <= 2'd0; irq <= 1'b0;
      end
    end else begin
      if (key_wr) unlk <= bus_wdata[15:0] == KEY;
      if (run && wd_tick) begin
        if (cnt <= PW'(1)) begin
          cnt <= per;
          if (exp_n == 2'd3) begin
            if (re) rst_req <= 1'b1;
          end else exp_n <= exp_n + 2'd1;
          if (exp_n == 2'd0 && ie) irq <= 1'b1;
        end else cnt <= cnt - 1'b1;
      end
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[TID_W-1:0] = sel;
        bus_rdata[11:4] = per;
        bus_rdata[12] = ie;
        bus_rdata[15] = re;
      end
      A_STS: begin
        bus_rdata[0] = run;
        bus_rdata[11:4] = cnt;
        bus_rdata[13:12] = exp_n;
      end
      A_TMR: begin
        bus_rdata[31] = t_en;
        bus_rdata[30] = t_rep;
        bus_rdata[TPER_W-1:0] = t_per;
      end
      default: bus_rdata = '0;
    endcase
  end

  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  a_r5_stop_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(unlk && cmd_wr));
  a_r3_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
    exp_n != $past(exp_n) |-> (exp_n == $past(exp_n) + 2'd1 || exp_n == 2'd0));
  a_r7_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> exp_n == 2'd1);
  a_r9_foreign_id: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != TID_W'(TIMER_ID) && !cmd_wr) |=> $stable(cnt));
endmodule

// File: tb/sim_wdog_tick.sv
module sim_wdog_tick;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rst_req;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  wdog_tick u0 (.clk(clk), .rst_n(rst_n), .us_tick(1'b1), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .rst_req(rst_req));

  // op: 0 write, 1 read and compare, 2 idle cycles, 3 compare {rst_req,irq}
  localparam int N = 31;
  localparam logic [83:0] VEC [N] = '{
    {8'd2, 4'd0, 8'h00, 32'h0000_9035, 32'h0},
    {8'd2, 4'd1, 8'h00, 32'h0,         32'h0000_9035},
    {8'd4, 4'd0, 8'h08, 32'h1,         32'h0},
    {8'd1, 4'd0, 8'h10, 32'hC000_0004, 32'h0},
    {8'd1, 4'd1, 8'h10, 32'h0,         32'hC000_0004},
    {8'd3, 4'd2, 8'h00, 32'd3,         32'h0},
    {8'd3, 4'd1, 8'h04, 32'h0,         32'h31},
    {8'd3, 4'd2, 8'h00, 32'd1,         32'h0},
    {8'd3, 4'd1, 8'h04, 32'h0,         32'h21},
    {8'd3, 4'd2, 8'h00, 32'd8,         32'h0},
    {8'd3, 4'd1, 8'h04, 32'h0,         32'h1031},
    {8'd7, 4'd3, 8'h00, 32'h0,         32'h1},
    {8'd4, 4'd0, 8'h08, 32'h1,         32'h0},
    {8'd4, 4'd1, 8'h04, 32'h0,         32'h31},
    {8'd7, 4'd3, 8'h00, 32'h0,         32'h0},
    {8'd5, 4'd0, 8'h08, 32'h2,         32'h0},
    {8'd5, 4'd1, 8'h04, 32'h0,         32'h31},
    {8'd5, 4'd0, 8'h0C, 32'hC45A,      32'h0},
    {8'd5, 4'd0, 8'h08, 32'h2,         32'h0},
    {8'd5, 4'd1, 8'h04, 32'h0,         32'h30},
    {8'd5, 4'd2, 8'h00, 32'd20,        32'h0},
    {8'd5, 4'd1, 8'h04, 32'h0,         32'h30},
    {8'd4, 4'd0, 8'h08, 32'h1,         32'h0},
    {8'd8, 4'd2, 8'h00, 32'd46,        32'h0},
    {8'd8, 4'd1, 8'h04, 32'h0,         32'h3011},
    {8'd8, 4'd3, 8'h00, 32'h0,         32'h1},
    {8'd8, 4'd2, 8'h00, 32'd1,         32'h0},
    {8'd8, 4'd3, 8'h00, 32'h0,         32'h3},
    {8'd8, 4'd1, 8'h04, 32'h0,         32'h3031},
    {8'd8, 4'd2, 8'h00, 32'd10,        32'h0},
    {8'd8, 4'd3, 8'h00, 32'h0,         32'h3}
  };

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, expv);
    end
  endtask

  task automatic rd(input int r, input logic [4:0] a, input logic [31:0] m, input logic [31:0] expv);
    addr = a; #1; chk(r, rdata & m, expv);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; we = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset;
    // R10: reset state
    rd(10, 5'h04, '1, 32'h0);
    rd(10, 5'h00, '1, 32'h0);
    rd(10, 5'h10, '1, 32'h0);
    chk(10, {30'd0, rst_req, irq}, 32'h0);

    // R1 R2 R3 R4 R5 R7 R8 via table
    for (int i = 0; i < N; i++) begin
      case (VEC[i][75:72])
        4'd0: wr(VEC[i][68:64], VEC[i][63:32]);
        4'd1: rd(int'(VEC[i][83:76]), VEC[i][68:64], '1, VEC[i][31:0]);
        4'd2: idle(int'(VEC[i][63:32]));
        default: chk(int'(VEC[i][83:76]), {30'd0, rst_req, irq}, VEC[i][31:0]);
      endcase
    end

    // R9: foreign tick source leaves count still
    do_reset;
    wr(5'h00, 32'h9032); wr(5'h08, 32'h1); wr(5'h10, 32'hC000_0004);
    idle(30);
    rd(9, 5'h04, '1, 32'h31);

    // R6: empty command consumes the key
    do_reset;
    wr(5'h00, 32'h9035); wr(5'h08, 32'h1);
    wr(5'h0C, 32'hC45A); wr(5'h08, 32'h0); wr(5'h08, 32'h2);
    rd(6, 5'h04, '1, 32'h31);

    // R8: reset enable clear never raises rst_req
    do_reset;
    wr(5'h00, 32'h1035); wr(5'h08, 32'h1); wr(5'h10, 32'hC000_0004);
    idle(80);
    rd(8, 5'h04, 32'h3000, 32'h3000);
    chk(8, {30'd0, rst_req, irq}, 32'h1);

    // R1: one-shot clears enable, zero write stops ticks
    do_reset;
    wr(5'h00, 32'h1035); wr(5'h08, 32'h1); wr(5'h10, 32'h8000_0004);
    idle(20);
    rd(1, 5'h04, '1, 32'h21);
    rd(1, 5'h10, '1, 32'h0000_0004);
    wr(5'h10, 32'hC000_0004);
    idle(4);
    rd(1, 5'h04, '1, 32'h11);
    idle(1);
    wr(5'h10, 32'h0);
    idle(20);
    rd(1, 5'h04, '1, 32'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule